// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block models what a flash device reports on its read path and on its ready/busy pin while an internally timed program or erase is under way. A start pulse, qualified by a two-bit operation kind and the last data word loaded by the host, begins a busy window whose length is fixed for each kind and set in clock cycles by a parameter. While the window is open, every read returns polling status in place of array data. Bit 7 carries the complement of bit 7 of the loaded word. Bit 6 changes value on each read. The ready/busy output is pulled low.

A hardware reset pulse that arrives during an operation cuts the operation short. The block then stays busy for a bounded recovery window and returns to plain read mode. When no operation is running, reads pass the array data through untouched. Array storage and command decoding sit outside this block. The start pulse is expected from the command decoder on the write strobe edge that completes a sequence.

Top module: `flash_busy_status`

## Requirements
- R1: While rst_ni is low and after it is released with no start, busy_no is 1 and rd_data_o equals array_data_i.
- R2: A start_i accepted in idle drives busy_no low from the next clock edge for exactly the kind's duration in cycles. The kind encoding is 0 program (PROG_CYC), 1 sector erase (SECTOR_CYC), 2 block erase (BLOCK_CYC) and 3 chip erase (CHIP_CYC). busy_no then returns to 1.
- R3: While busy, rd_data_o bit 7 is the inverse of bit 7 of load_data_i sampled on the accepting start. Later changes of load_data_i have no effect until the next accepted start.
- R4: While busy, rd_data_o bit 6 reads 0 on the first read after an accepted start and inverts after each cycle with rd_i high. It does not change in cycles without rd_i.
- R5: While busy, all bits other than 7 and 6 follow array_data_i. When ready, every bit of rd_data_o follows array_data_i.
- R6: start_i while busy is ignored: the running window is neither restarted nor extended, and the captured bit 7 and the bit-6 sequence are kept.
- R7: hard_rst_i high while an operation runs ends the operation and keeps busy_no low for exactly RECOV_CYC cycles from that edge. Status reads continue during this window, and then the block is ready.
- R8: hard_rst_i has no effect when idle or during recovery. When hard_rst_i and start_i are both high in idle, nothing starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start of an internal operation |
| op_kind_i | input | 2 | Operation kind, sampled with start_i |
| load_data_i | input | DATA_W | Last data word loaded by the host |
| hard_rst_i | input | 1 | Hardware reset pulse, aborts a running operation |
| rd_i | input | 1 | Read strobe, one cycle per read |
| array_data_i | input | DATA_W | Data from the array for the current read |
| rd_data_o | output | DATA_W | Read data or polling status |
| busy_no | output | 1 | Ready/busy, low while busy, 1 when released |

## Verification
The bench measures each busy window from the start edge to the release and compares it with the kind's duration. A counter that is off by one cycle, or a kind decode that is swapped, shows up as a wrong cycle count. It issues a second start and a changed data word in the middle of a window. A design that restarts its timer or resamples the data would lengthen the window or flip bit 7. It spaces reads irregularly, including reads just after a start, so a toggle that moves without a read, or that does not start from 0, is caught. It also pulses the hardware reset in the last busy cycle, during recovery and while idle, and checks in each case that recovery is exactly its window and is neither restarted nor started from idle.

// File: rtl/flash_stat_pkg.sv
`timescale 1ns/1ps
package flash_stat_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_RECOV = 2'd2
  } phase_e;

  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

endpackage

// File: rtl/op_timer.sv
`timescale 1ns/1ps
module op_timer
  import flash_stat_pkg::*;
#(
  parameter int unsigned PROG_CYC   = 20,
  parameter int unsigned SECTOR_CYC = 64,
  parameter int unsigned BLOCK_CYC  = 96,
  parameter int unsigned CHIP_CYC   = 128,
  parameter int unsigned RECOV_CYC  = 10,
  parameter int unsigned CW         = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] kind_i,
  input  logic       hard_rst_i,
  output logic       busy_o,
  output logic       launch_o
);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] dur_sel;
  logic          cnt_zero;

  always_comb begin
    unique case (op_kind_e'(kind_i))
      OP_PROG:   dur_sel = CW'(PROG_CYC - 1);
      OP_SECTOR: dur_sel = CW'(SECTOR_CYC - 1);
      OP_BLOCK:  dur_sel = CW'(BLOCK_CYC - 1);
      default:   dur_sel = CW'(CHIP_CYC - 1);
    endcase
  end

  assign cnt_zero = (cnt_q == '0);
  // hardware reset wins over a start in the same cycle
  assign launch_o = (phase_q == PH_IDLE) && start_i && !hard_rst_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (launch_o) begin
          phase_d = PH_RUN;
          cnt_d   = dur_sel;
        end
      end
      PH_RUN: begin
        if (hard_rst_i) begin
          phase_d = PH_RECOV;
          cnt_d   = CW'(RECOV_CYC - 1);
        end else if (cnt_zero) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RECOV: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (phase_q != PH_IDLE);

  AST_RUN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && cnt_zero && !hard_rst_i) |=> (phase_q == PH_IDLE)); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && !cnt_zero && start_i && !hard_rst_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_ABORT_RECOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && hard_rst_i) |=> (phase_q == PH_RECOV && cnt_q == CW'(RECOV_CYC - 1))); // R7
  AST_RECOV_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RECOV && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_IDLE_HARD_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && hard_rst_i) |=> (phase_q == PH_IDLE)); // R8

endmodule

// File: rtl/status_mux.sv
`timescale 1ns/1ps
module status_mux
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              busy_i,
  input  logic              rd_i,
  input  logic              poll_src_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic poll_q;
  logic tog_q;

  // only bit 7 of the loaded word is kept; the rest is never reported
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= 1'b0;
      tog_q  <= 1'b0;
    end else if (launch_i) begin
      poll_q <= ~poll_src_i;
      tog_q  <= 1'b0;
    end else if (busy_i && rd_i) begin
      tog_q  <= ~tog_q;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign rd_data_o[b] = busy_i ? poll_q : array_data_i[b];
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign rd_data_o[b] = busy_i ? tog_q : array_data_i[b];
    end else begin : g_pass
      assign rd_data_o[b] = array_data_i[b];
    end
  end

  AST_TOG_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i) |=> (tog_q != $past(tog_q))); // R4
  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !launch_i) |=> $stable(tog_q)); // R4
  AST_POLL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i) |=> $stable(poll_q)); // R3

endmodule

// File: rtl/flash_busy_status.sv
`timescale 1ns/1ps
module flash_busy_status
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PROG_CYC   = 20,
  parameter int unsigned SECTOR_CYC = 64,
  parameter int unsigned BLOCK_CYC  = 96,
  parameter int unsigned CHIP_CYC   = 128,
  parameter int unsigned RECOV_CYC  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_kind_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              hard_rst_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_no
);

  localparam int unsigned MAX_AB  = (PROG_CYC > SECTOR_CYC) ? PROG_CYC : SECTOR_CYC;
  localparam int unsigned MAX_CD  = (BLOCK_CYC > CHIP_CYC) ? BLOCK_CYC : CHIP_CYC;
  localparam int unsigned MAX_OP  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned MAX_ALL = (MAX_OP > RECOV_CYC) ? MAX_OP : RECOV_CYC;
  localparam int unsigned CW      = $clog2(MAX_ALL + 1);

  logic busy;
  logic launch;

  op_timer #(
    .PROG_CYC  (PROG_CYC),
    .SECTOR_CYC(SECTOR_CYC),
    .BLOCK_CYC (BLOCK_CYC),
    .CHIP_CYC  (CHIP_CYC),
    .RECOV_CYC (RECOV_CYC),
    .CW        (CW)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .kind_i    (op_kind_i),
    .hard_rst_i(hard_rst_i),
    .busy_o    (busy),
    .launch_o  (launch)
  );

  status_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .busy_i      (busy),
    .rd_i        (rd_i),
    .poll_src_i  (load_data_i[POLL_BIT]),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o)
  );

  // open-drain release modelled as 1
  assign busy_no = ~busy;

  AST_READY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no |-> (rd_data_o == array_data_i)); // R5
  AST_START_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_no && start_i && !hard_rst_i) |=> !busy_no); // R2

endmodule

// File: tb/flash_busy_status_test.sv
`timescale 1ns/1ps
module flash_busy_status_test;

  localparam int DW = 16;
  localparam int P_CYC = 20, S_CYC = 64, B_CYC = 96, C_CYC = 128, RC_CYC = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_kind_i = '0;
  logic [DW-1:0] load_data_i = '0;
  logic          hard_rst_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] array_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          busy_no;

  int n_tests = 0, n_fail = 0;
  int m_phase = 0, m_left = 0;
  logic m_b7 = 1'b0, m_tog = 1'b0;
  int meas;

  always #10 clk = ~clk;

  flash_busy_status #(
    .DATA_W(DW), .PROG_CYC(P_CYC), .SECTOR_CYC(S_CYC),
    .BLOCK_CYC(B_CYC), .CHIP_CYC(C_CYC), .RECOV_CYC(RC_CYC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_kind_i(op_kind_i),
    .load_data_i(load_data_i), .hard_rst_i(hard_rst_i), .rd_i(rd_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o), .busy_no(busy_no)
  );

  function automatic int dur_of(input logic [1:0] k);
    case (k)
      2'd0: return P_CYC;
      2'd1: return S_CYC;
      2'd2: return B_CYC;
      default: return C_CYC;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [DW-1:0] arr, input logic bsy,
                                            input logic b7, input logic t6);
    logic [DW-1:0] r;
    r = arr;
    if (bsy) begin
      r[7] = b7;
      r[6] = t6;
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic [1:0] k, input logic [DW-1:0] d,
                     input logic hr, input logic rd, input logic [DW-1:0] arr,
                     input string btag);
    logic          eb;
    logic [DW-1:0] ed;
    logic [DW-1:0] msk;
    start_i = st; op_kind_i = k; load_data_i = d; hard_rst_i = hr;
    rd_i = rd; array_data_i = arr;
    #1;
    eb = (m_phase != 0);
    ed = exp_data(arr, eb, ~m_b7, m_tog);
    chk(busy_no === ~eb, btag, {{(DW-1){1'b0}}, busy_no}, {{(DW-1){1'b0}}, ~eb});
    if (eb) begin
      chk(rd_data_o[7] === ed[7], "R3 poll bit", rd_data_o, ed);
      if (rd) chk(rd_data_o[6] === ed[6], "R4 toggle bit", rd_data_o, ed);
    end
    msk = eb ? ~(DW'(16'h00C0)) : '1;
    chk((rd_data_o & msk) === (ed & msk), "R5 pass bits", rd_data_o, ed);
    @(posedge clk);
    if (eb && rd) m_tog = ~m_tog;
    if (m_phase == 1) begin
      if (hr) begin m_phase = 2; m_left = RC_CYC; end
      else begin m_left--; if (m_left == 0) m_phase = 0; end
    end else if (m_phase == 2) begin
      m_left--; if (m_left == 0) m_phase = 0;
    end else if (st && !hr) begin
      m_phase = 1; m_left = dur_of(k); m_b7 = d[7]; m_tog = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic run_out(input string tag, output int n);
    n = 0;
    while (busy_no == 1'b0 && n < 1000) begin
      n++;
      cyc(1'b0, 2'd0, DW'($urandom), 1'b0, 1'($urandom), DW'($urandom), tag);
    end
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3d_5a77));
    array_data_i = 16'hA5C3;
    #25;
    chk(busy_no === 1'b1, "R1 reset busy", {15'd0, busy_no}, 16'd1);
    chk(rd_data_o === 16'hA5C3, "R1 reset data", rd_data_o, 16'hA5C3);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, DW'($urandom), "R1 idle");

    // program, bit7 of loaded word = 1, second start and data change mid window
    cyc(1'b1, 2'd0, 16'h0080, 1'b0, 1'b0, 16'h1234, "R2 start");
    meas = 0;
    for (int i = 0; i < 6; i++) begin
      meas++;
      cyc(1'b0, 2'd0, 16'h0000, 1'b0, i[0], 16'hFFFF, "R3 data change");
    end
    meas++;
    cyc(1'b1, 2'd3, 16'h0000, 1'b0, 1'b1, 16'h00FF, "R6 start while busy");
    begin
      int rest;
      run_out("R6 window", rest);
      meas += rest;
    end
    chk(meas == P_CYC, "R6 window length", DW'(meas), DW'(P_CYC));

    // every kind, exact duration
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 2'(k), DW'($urandom), 1'b0, 1'b1, DW'($urandom), "R2 start kind");
      run_out("R2 busy", meas);
      chk(meas == dur_of(2'(k)), "R2 duration", DW'(meas), DW'(dur_of(2'(k))));
    end

    // abort mid-operation
    cyc(1'b1, 2'd3, 16'h0000, 1'b0, 1'b0, 16'h0, "R7 start");
    for (int i = 0; i < 5; i++) cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 16'h3C3C, "R7 run");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 16'h3C3C, "R7 abort");
    run_out("R7 recovery", meas);
    chk(meas == RC_CYC, "R7 recovery length", DW'(meas), DW'(RC_CYC));

    // abort in last busy cycle
    cyc(1'b1, 2'd0, 16'h0080, 1'b0, 1'b0, 16'h0, "R7 start");
    for (int i = 0; i < P_CYC - 1; i++) cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 16'h0, "R7 run");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 16'h0, "R7 abort last");
    run_out("R7 recovery last", meas);
    chk(meas == RC_CYC, "R7 recovery after last", DW'(meas), DW'(RC_CYC));

    // hardware reset during recovery ignored
    cyc(1'b1, 2'd1, 16'h0, 1'b0, 1'b0, 16'h0, "R8 start");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 16'h0, "R8 abort");
    meas = 0;
    for (int i = 0; i < 3; i++) begin
      meas++;
      cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 16'h0, "R8 recovery");
    end
    meas++;
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 16'h0, "R8 second reset");
    begin
      int rest;
      run_out("R8 recovery", rest);
      meas += rest;
    end
    chk(meas == RC_CYC, "R8 recovery not restarted", DW'(meas), DW'(RC_CYC));

    // reset while idle, reset with start while idle
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 16'h5A5A, "R8 idle reset");
    cyc(1'b1, 2'd2, 16'h0080, 1'b1, 1'b1, 16'h5A5A, "R8 reset+start");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 16'h6969, "R8 stays ready");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 12) == 0, 2'($urandom), DW'($urandom), ($urandom % 50) == 0,
          1'($urandom), DW'($urandom), "R2 random busy");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule